// File: doc/BRIEF.md
# Double-Buffered Angle Preset Input

This block is the digital input path of a tracking angle converter when it is switched to work as a control transformer. In that mode the host supplies a target angle one byte at a time over a byte-wide bus. Each byte goes into its own first-rank holding register under its own strobe. A separate transfer control then moves both bytes at once into a second-rank register, whose contents preset the converter's angle register. Because of the two ranks, the host can stage a new angle while the previous one still drives the loop, and the loop sees the new angle all at once.

The mode input selects the behaviour. When it is 1 the converter tracks normally. The strobe and transfer pins then carry their usual output-enable and inhibit meanings, and this block ignores them. When it is 0 the strobes and the transfer control act as latch controls. The byte registers follow the bus while their strobe is low and hold while it is high. The second rank is the other way round: it follows while the transfer control is high and holds while it is low. The loaded angle is cut to the selected resolution. A timing monitor counts clock cycles and flags strobes that are too short, data that changes too soon after a strobe closes, data set up too late, and a transfer that starts too soon after a byte strobe.

Top module: `ct_angle_loader`

## Requirements
- R1: While reset is high, and in the cycle after it, `ct_active`, `angle_out`, `preset_we` and `viol` are all 0.
- R2: `ct_active` equals the inverse of `track_en`, delayed by one clock. While `track_en` is 1, strobes, transfer and data have no effect: `angle_out` keeps its value and `preset_we` stays 0.
- R3: In control-transformer mode, each clock edge at which `hi_strobe` is 0 copies `data_in` into the high byte (bits 15:8), and each edge at which `lo_strobe` is 0 copies it into the low byte (bits 7:0). A byte whose strobe is 1 holds its value, whatever `data_in` does.
- R4: At each edge at which `xfer_ctl` is 1 in control-transformer mode, the second rank loads the staged {high, low} bytes and `preset_we` is 1 for the following cycle. While `xfer_ctl` is 0, `angle_out` holds even when the byte registers change.
- R5: On a load, bits below the active resolution are forced to 0. `res_sel` 0 selects 10 bits (bits 5:0 cleared), 1 selects 12 bits (bits 3:0 cleared), 2 selects 14 bits (bits 1:0 cleared) and 3 selects all 16 bits.
- R6: In the first cycle of control-transformer mode, both byte registers and the second rank are cleared to 0. This takes priority over a load in the same cycle, so a transfer held high across the mode entry delivers 0.
- R7: `viol[0]` pulses when a strobe is released after being low for fewer than PW_CYC cycles (default 20).
- R8: `viol[1]` pulses when `data_in` changes within DH_CYC cycles (default 10) after a strobe rises. `viol[2]` pulses when a strobe rises with data stable for fewer than DSU_CYC cycles (default 0, so it never fires).
- R9: `viol[3]` pulses when `xfer_ctl` rises fewer than XSU_CYC cycles (default 60) after the last strobe rise. A transfer with a larger gap raises no flag.
- R10: `viol` is 0 while `track_en` is 1 and in the entry cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| track_en | input | 1 | 1 = normal tracking, 0 = control-transformer input mode |
| hi_strobe | input | 1 | High-byte latch control in input mode (0 = follow, 1 = hold) |
| lo_strobe | input | 1 | Low-byte latch control in input mode (0 = follow, 1 = hold) |
| xfer_ctl | input | 1 | Second-rank control in input mode (1 = follow, 0 = hold) |
| data_in | input | BYTE_W | Byte-wide host data bus |
| res_sel | input | 2 | Resolution select, 0..3 = 10/12/14/16 bits |
| ct_active | output | 1 | Registered indication of input mode |
| angle_out | output | 2*BYTE_W | Preset angle from the second rank |
| preset_we | output | 1 | High in each cycle after a second-rank load |
| viol | output | 4 | Timing flags: 0 width, 1 hold, 2 setup, 3 transfer setup |

## Verification
The clear on mode entry and a second-rank load can fall in the same cycle. The bench provokes this by dropping `track_en` while `xfer_ctl` is already high and both byte registers still hold nonzero bytes from an earlier session. The clear must win: the scoreboard expects a preset of 0, and `angle_out` is sampled as 0 while the transfer stays high. A design that let the load through, or that cleared only the second rank, would deliver the old bytes instead.

// File: rtl/ctin_pkg.sv
package ctin_pkg;
  typedef enum logic [1:0] {
    RES_10 = 2'd0,
    RES_12 = 2'd1,
    RES_14 = 2'd2,
    RES_16 = 2'd3
  } res_e;

  localparam int VIOL_N     = 4;
  localparam int VI_WIDTH   = 0;
  localparam int VI_HOLD    = 1;
  localparam int VI_SETUP   = 2;
  localparam int VI_XFER    = 3;
endpackage

// File: rtl/ctin_byte_rank.sv
module ctin_byte_rank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         run,
  input  logic         strobe,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      q <= '0;
    end else if (run && !strobe) begin
      q <= din;
    end
  end
endmodule

// File: rtl/ctin_final_rank.sv
module ctin_final_rank #(
  parameter int BYTE_W   = 8,
  parameter int RES_MIN  = 10,
  parameter int RES_STEP = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clear,
  input  logic                  run,
  input  logic                  xfer,
  input  logic [1:0]            res_sel,
  input  logic [2*BYTE_W-1:0]   staged,
  output logic [2*BYTE_W-1:0]   angle_q,
  output logic                  we_q
);
  localparam int AW = 2 * BYTE_W;

  logic [AW-1:0] keep_mask;
  int            keep_bits;

  always_comb begin
    keep_bits = RES_MIN + RES_STEP * int'(res_sel);
    if (keep_bits > AW) keep_bits = AW;
    for (int i = 0; i < AW; i++) begin
      keep_mask[i] = (i >= AW - keep_bits);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      angle_q <= '0;
      we_q    <= 1'b0;
    end else begin
      we_q <= run && xfer;
      if (run && xfer) begin
        angle_q <= staged & keep_mask;
      end
    end
  end
endmodule

// File: rtl/ctin_timing_mon.sv
module ctin_timing_mon
  import ctin_pkg::*;
#(
  parameter int W       = 8,
  parameter int PW_CYC  = 20,
  parameter int DH_CYC  = 10,
  parameter int DSU_CYC = 0,
  parameter int XSU_CYC = 60
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [1:0]        stb,
  input  logic              xfer,
  input  logic [W-1:0]      din,
  output logic [VIOL_N-1:0] viol
);
  localparam int PCW   = $clog2(PW_CYC + 2);
  localparam int HCW   = $clog2(DH_CYC + 2);
  localparam int SCW   = $clog2(DSU_CYC + 2);
  localparam int XCW   = $clog2(XSU_CYC + 2);
  localparam int HLOAD = (DH_CYC > 0) ? DH_CYC - 1 : 0;

  logic [1:0] rise;
  logic [1:0] wfail;

  for (genvar g = 0; g < 2; g++) begin : g_stb
    logic           s_q;
    logic [PCW-1:0] low_cnt;

    assign rise[g]  = run && stb[g] && !s_q;
    assign wfail[g] = rise[g] && (int'(low_cnt) < PW_CYC);

    always_ff @(posedge clk) begin
      if (rst || !run) begin
        s_q     <= 1'b1;
        low_cnt <= '0;
      end else begin
        s_q <= stb[g];
        if (stb[g]) begin
          low_cnt <= '0;
        end else if (int'(low_cnt) < PW_CYC) begin
          low_cnt <= low_cnt + 1'b1;
        end
      end
    end
  end

  logic           any_rise;
  logic [W-1:0]   data_q;
  logic [HCW-1:0] hold_cnt;
  logic [SCW-1:0] stable_cnt;
  logic [XCW-1:0] since_cnt;
  logic           x_q;
  logic           chg;
  logic           hold_fail;
  logic           setup_fail;
  logic           x_rise;
  logic           xfail;

  assign any_rise   = |rise;
  assign chg        = (din != data_q);
  assign hold_fail  = run && chg && ((any_rise && (DH_CYC > 0)) || (hold_cnt != '0));
  assign setup_fail = any_rise && (int'(stable_cnt) < DSU_CYC);
  assign x_rise     = run && xfer && !x_q;
  assign xfail      = x_rise && (int'(since_cnt) < XSU_CYC);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      data_q     <= din;
      hold_cnt   <= '0;
      stable_cnt <= '0;
      since_cnt  <= XCW'(XSU_CYC);
      x_q        <= 1'b1;
    end else begin
      data_q <= din;
      x_q    <= xfer;
      if (any_rise) begin
        hold_cnt <= HCW'(HLOAD);
      end else if (hold_cnt != '0) begin
        hold_cnt <= hold_cnt - 1'b1;
      end
      if (chg) begin
        stable_cnt <= '0;
      end else if (int'(stable_cnt) < DSU_CYC) begin
        stable_cnt <= stable_cnt + 1'b1;
      end
      if (any_rise) begin
        since_cnt <= '0;
      end else if (int'(since_cnt) < XSU_CYC) begin
        since_cnt <= since_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      viol <= '0;
    end else begin
      viol[VI_WIDTH] <= |wfail;
      viol[VI_HOLD]  <= hold_fail;
      viol[VI_SETUP] <= setup_fail;
      viol[VI_XFER]  <= xfail;
    end
  end
endmodule

// File: rtl/ct_angle_loader.sv
module ct_angle_loader
  import ctin_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int RES_MIN  = 10,
  parameter int RES_STEP = 2,
  parameter int PW_CYC   = 20,
  parameter int DH_CYC   = 10,
  parameter int DSU_CYC  = 0,
  parameter int XSU_CYC  = 60
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                track_en,
  input  logic                hi_strobe,
  input  logic                lo_strobe,
  input  logic                xfer_ctl,
  input  logic [BYTE_W-1:0]   data_in,
  input  logic [1:0]          res_sel,
  output logic                ct_active,
  output logic [2*BYTE_W-1:0] angle_out,
  output logic                preset_we,
  output logic [VIOL_N-1:0]   viol
);
  localparam int AW = 2 * BYTE_W;

  logic          ct_q;
  logic          entry;
  logic          run;
  logic [1:0]    stb;
  logic [AW-1:0] staged;

  always_ff @(posedge clk) begin
    if (rst) ct_q <= 1'b0;
    else     ct_q <= !track_en;
  end

  assign entry     = !track_en && !ct_q;
  assign run       = !track_en && ct_q;
  assign ct_active = ct_q;
  assign stb       = {hi_strobe, lo_strobe};

  for (genvar g = 0; g < 2; g++) begin : g_byte
    ctin_byte_rank #(.W(BYTE_W)) u_byte (
      .clk    (clk),
      .rst    (rst),
      .clear  (entry),
      .run    (run),
      .strobe (stb[g]),
      .din    (data_in),
      .q      (staged[g*BYTE_W +: BYTE_W])
    );
  end

  ctin_final_rank #(
    .BYTE_W   (BYTE_W),
    .RES_MIN  (RES_MIN),
    .RES_STEP (RES_STEP)
  ) u_final (
    .clk     (clk),
    .rst     (rst),
    .clear   (entry),
    .run     (run),
    .xfer    (xfer_ctl),
    .res_sel (res_sel),
    .staged  (staged),
    .angle_q (angle_out),
    .we_q    (preset_we)
  );

  ctin_timing_mon #(
    .W       (BYTE_W),
    .PW_CYC  (PW_CYC),
    .DH_CYC  (DH_CYC),
    .DSU_CYC (DSU_CYC),
    .XSU_CYC (XSU_CYC)
  ) u_mon (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .stb  (stb),
    .xfer (xfer_ctl),
    .din  (data_in),
    .viol (viol)
  );
endmodule

// File: rtl/ct_angle_loader_chk.sv
module ct_angle_loader_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          track_en,
  input logic          xfer_ctl,
  input logic          ct_active,
  input logic [AW-1:0] angle_out,
  input logic          preset_we,
  input logic [3:0]    viol
);
  AST_TRACK_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    track_en |=> (!preset_we && $stable(angle_out))); // R2

  AST_MODE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    track_en |=> !ct_active); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!track_en && ct_active && !xfer_ctl) |=> $stable(angle_out)); // R4

  AST_WE_IN_MODE: assert property (@(posedge clk) disable iff (rst)
    preset_we |-> ct_active); // R4

  AST_ENTRY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (!track_en && !ct_active) |=> (angle_out == '0 && !preset_we)); // R6

  AST_VIOL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (track_en || !ct_active) |=> (viol == 4'b0000)); // R10
endmodule

bind ct_angle_loader ct_angle_loader_chk #(.AW(2*BYTE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .track_en  (track_en),
  .xfer_ctl  (xfer_ctl),
  .ct_active (ct_active),
  .angle_out (angle_out),
  .preset_we (preset_we),
  .viol      (viol)
);

// File: tb/test_ct_angle_loader.sv
`timescale 1ns/1ps
module test_ct_angle_loader;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        track_en = 1'b1;
  logic        hi_s = 1'b1;
  logic        lo_s = 1'b1;
  logic        xfer = 1'b0;
  logic [7:0]  din = 8'h00;
  logic [1:0]  res = 2'd3;
  logic        ct_active;
  logic [15:0] angle_out;
  logic        preset_we;
  logic [3:0]  viol;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        we_prev = 1'b0;
  logic [3:0]  seen_viol = 4'b0;
  logic        seen_we = 1'b0;

  always #2.5 clk = ~clk;

  ct_angle_loader i_ct_angle_loader (
    .clk(clk), .rst(rst), .track_en(track_en), .hi_strobe(hi_s),
    .lo_strobe(lo_s), .xfer_ctl(xfer), .data_in(din), .res_sel(res),
    .ct_active(ct_active), .angle_out(angle_out), .preset_we(preset_we),
    .viol(viol)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] masked(input logic [15:0] v, input logic [1:0] r);
    case (r)
      2'd0:    return v & 16'hFFC0;
      2'd1:    return v & 16'hFFF0;
      2'd2:    return v & 16'hFFFC;
      default: return v;
    endcase
  endfunction

  // monitor: compare each completed load with the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      seen_viol = seen_viol | viol;
      seen_we   = seen_we | preset_we;
      if (we_prev && !preset_we) begin
        if (exp_q.size() == 0) begin
          chk("R4 unexpected load", {16'h0, angle_out}, 32'hFFFF_FFFF);
        end else begin
          chk(tag_q.pop_front(), {16'h0, angle_out}, {16'h0, exp_q.pop_front()});
        end
      end
    end
    we_prev = preset_we;
  end

  task automatic wr_byte(input bit hi, input logic [7:0] v, input int pw, input int hold);
    @(negedge clk);
    din = v;
    if (hi) hi_s = 1'b0; else lo_s = 1'b0;
    repeat (pw) @(negedge clk);
    hi_s = 1'b1;
    lo_s = 1'b1;
    repeat (hold) @(negedge clk);
  endtask

  task automatic xfer_pulse(input int gap);
    repeat (gap) @(negedge clk);
    xfer = 1'b1;
    repeat (2) @(negedge clk);
    xfer = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic load(input logic [15:0] v, input logic [1:0] r, input string tag);
    res = r;
    wr_byte(1'b1, v[15:8], 25, 15);
    wr_byte(1'b0, v[7:0], 25, 15);
    exp_q.push_back(masked(v, r));
    tag_q.push_back(tag);
    xfer_pulse(70);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk("R1 angle", {16'h0, angle_out}, 32'h0);
    chk("R1 flags", {28'h0, ct_active, preset_we, viol[1:0]} | {28'h0, viol}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", {15'h0, angle_out, preset_we}, 32'h0);

    track_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 ct_active", {31'h0, ct_active}, 32'h1);

    seen_viol = 4'b0;
    load(16'h1234, 2'd3, "R3 byte order 16-bit");
    load(16'hFFFF, 2'd0, "R5 10-bit mask");
    load(16'hABCD, 2'd1, "R5 12-bit mask");
    load(16'h5A5B, 2'd2, "R5 14-bit mask");
    chk("R9 legal timing no flags", {28'h0, seen_viol}, 32'h0);

    // R4: stage new bytes without transfer, output must hold
    wr_byte(1'b1, 8'h99, 25, 15);
    wr_byte(1'b0, 8'h99, 25, 15);
    repeat (10) @(negedge clk);
    chk("R4 hold without transfer", {16'h0, angle_out}, 32'h5A58);
    exp_q.push_back(16'h9998); tag_q.push_back("R4 transfer after staging");
    xfer_pulse(70);

    // R3: bus activity with strobes high must not alter staged bytes
    din = 8'hEE;
    repeat (5) @(negedge clk);
    din = 8'h01;
    exp_q.push_back(16'h9998); tag_q.push_back("R3 bytes hold while strobe high");
    xfer_pulse(70);

    // R7: short strobe
    seen_viol = 4'b0;
    wr_byte(1'b1, 8'h11, 3, 15);
    chk("R7 width flag", {31'h0, seen_viol[0]}, 32'h1);

    // R8: data change inside hold window
    seen_viol = 4'b0;
    wr_byte(1'b0, 8'h22, 25, 2);
    din = 8'h33;
    repeat (15) @(negedge clk);
    chk("R8 hold flag", {31'h0, seen_viol[1]}, 32'h1);
    chk("R8 setup flag stays clear", {31'h0, seen_viol[2]}, 32'h0);

    // R9: transfer too soon after a strobe
    seen_viol = 4'b0;
    wr_byte(1'b1, 8'h44, 25, 0);
    exp_q.push_back(16'h4420); tag_q.push_back("R9 early transfer still loads");
    xfer_pulse(3);
    chk("R9 transfer setup flag", {31'h0, seen_viol[3]}, 32'h1);

    // R2 / R10: tracking mode ignores all controls
    track_en = 1'b1;
    repeat (3) @(negedge clk);
    seen_viol = 4'b0;
    seen_we = 1'b0;
    wr_byte(1'b1, 8'h77, 3, 1);
    wr_byte(1'b0, 8'h66, 3, 1);
    xfer_pulse(2);
    chk("R2 angle unchanged in tracking", {16'h0, angle_out}, 32'h4420);
    chk("R2 no load in tracking", {31'h0, seen_we}, 32'h0);
    chk("R10 no flags in tracking", {28'h0, seen_viol}, 32'h0);
    chk("R2 ct_active low", {31'h0, ct_active}, 32'h0);

    // R6: entry clear coincides with a held-high transfer
    res = 2'd3;
    exp_q.push_back(16'h0000); tag_q.push_back("R6 entry clear beats load");
    @(negedge clk);
    track_en = 1'b0;
    xfer = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 angle zero during transfer", {16'h0, angle_out}, 32'h0);
    xfer = 1'b0;
    repeat (4) @(negedge clk);

    load(16'hC3A5, 2'd3, "R3 full load after re-entry");

    repeat (10) @(negedge clk);
    chk("R4 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule